// File: doc/BRIEF.md
# Double-Banked Segment Integrator

This block builds long-term sums from short correlation dumps. The input is a stream of beats. Each beat carries one lag index and the partial results of `NSLICE` parallel correlator slices for that lag. The block adds the slices together, so the number of stored values is `NSLICE` times smaller than the number of partials. It then adds that slice total into a signed, saturating running sum held in RAM. Inside a segment every lag appears exactly once, in any order, and the final beat of the segment is marked. The RAM is split into two banks. One bank integrates while the other waits for readout or is being read.

The integration length is `int_segs` segments, so a dump always falls on a segment boundary. When the last segment of an integration has been written, three things happen. The banks swap roles, the completed bank is streamed out in lag order, and a per-dump overflow flag and a late-readout flag are published. The first segment written into the new active bank overwrites the stale contents rather than adding to them, so the bank is cleared without spending extra cycles. Accumulation is a two-stage read-modify-write. A result that is still being written is forwarded to a following update of the same lag.

The input side accepts a beat whenever `in_valid` is high; `in_ready` is held high, so the producer never sees back-pressure. The output stream follows valid/ready rules. When `out_valid` is high and `out_ready` is low, the data and the last marker hold. A beat transfers on a clock edge where both are high. Parameter constraints: `NLAG >= 2`, and `AW >= PW + clog2(NSLICE) + 1`.

Top module: `seg_integrator`

## Requirements
- R1: `in_ready` is high in every cycle after reset, including during a bank swap and while readout is in progress; each cycle with `in_valid` high is one accepted beat.
- R2: For every accepted beat, the signed sum of all `NSLICE` two's-complement partials (slice k in bits `k*PW +: PW` of `in_part`) is added to the entry for `in_lag` in the active bank.
- R3: The first segment written into a bank after reset or after a swap replaces the stored values; no contribution from an earlier integration is carried into a dump.
- R4: The integration ends at the end of the segment (a beat with `in_last` high) that brings the segment count to `int_segs`, where a value of 0 counts as 1. The banks then swap, and the next beat is accepted without a gap.
- R5: Two updates of the same lag on consecutive cycles, where the last beat of one segment and the first beat of the next hit the same lag, both contribute to the sum.
- R6: Each running sum saturates at the signed `AW`-bit limits, -2^(AW-1) and 2^(AW-1)-1, and does not wrap.
- R7: `dump_ovf` changes only when a dump is published. It is high exactly when at least one saturation occurred while that integration was being accumulated.
- R8: After a dump, the completed bank is streamed out with lag 0 first and `out_last` on lag `NLAG-1`, one value per transfer. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. `out_valid` falls after the last transfer.
- R9: `dump_late` is published with each dump. It is high when the previous readout had not finished. In that case the stream restarts at lag 0 of the new dump.
- R10: During and right after reset, `out_valid`, `dump_ovf` and `dump_late` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_segs | input | CW | Integration length in segments (0 counts as 1) |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Always high: input is never stalled |
| in_lag | input | clog2(NLAG) | Lag index of the beat |
| in_last | input | 1 | Final beat of a segment |
| in_part | input | NSLICE*PW | Packed signed slice partials |
| out_valid | output | 1 | Readout value present |
| out_ready | input | 1 | Consumer accepts readout value |
| out_data | output | AW | Signed long-term sum |
| out_last | output | 1 | Value is lag NLAG-1 |
| dump_ovf | output | 1 | Saturation occurred in the latest dump |
| dump_late | output | 1 | Latest dump arrived before the previous readout ended |

## Verification
The bench keeps the full slice count of 32 with 4-bit partials, but uses an `AW` of 10 bits and only 8 lags. With these values, saturation in either direction is reached within four segments, and a whole dump fits in a few dozen cycles. Many swaps, overruns and back-to-back same-lag updates at segment boundaries therefore fit into a short run. A 4-bit `CW` is enough to exercise a programmed count of zero alongside counts up to five.

// File: rtl/segint_pkg.sv
package segint_pkg;

  // Programmed integration length, with zero treated as one segment.
  function automatic int unsigned eff_len(input int unsigned prog);
    return (prog == 0) ? 1 : prog;
  endfunction

endpackage

// File: rtl/segint_slice_sum.sv
module segint_slice_sum #(
  parameter int NSLICE = 32,
  parameter int PW     = 4,
  parameter int SW     = 10
) (
  input  logic [NSLICE*PW-1:0] part,
  output logic signed [SW-1:0] sum
);

  logic signed [SW-1:0] ext [NSLICE];

  for (genvar g = 0; g < NSLICE; g++) begin : g_ext
    assign ext[g] = SW'($signed(part[g*PW +: PW]));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NSLICE; i++) sum = sum + ext[i];
  end

endmodule

// File: rtl/segint_sat_add.sv
module segint_sat_add #(
  parameter int AW = 24,
  parameter int SW = 10
) (
  input  logic signed [AW-1:0] base,
  input  logic signed [SW-1:0] addend,
  output logic signed [AW-1:0] res,
  output logic                 sat
);

  logic signed [AW:0] wide;

  always_comb begin
    wide = (AW+1)'(base) + (AW+1)'(addend);
    sat  = wide[AW] ^ wide[AW-1];
    res  = sat ? {wide[AW], {(AW-1){~wide[AW]}}} : wide[AW-1:0];
  end

  // Clipping only ever moves toward the sign of the addend.
  always_comb begin
    if (sat) begin
      assert_sat_dir_R6: assert (res[AW-1] == addend[SW-1]);
    end
  end

endmodule

// File: rtl/segint_readout.sv
module segint_readout #(
  parameter int NLAG = 64,
  parameter int LW   = 6,
  parameter int IW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_bank,
  input  logic          ready,
  output logic          valid,
  output logic          last,
  output logic [IW-1:0] addr,
  output logic          cur_bank
);

  logic [LW-1:0] ptr;
  logic          busy;

  assign valid = busy;
  assign last  = busy && (ptr == LW'(NLAG - 1));
  assign addr  = IW'(cur_bank ? NLAG : 0) + IW'(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ptr      <= '0;
      cur_bank <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      ptr      <= '0;
      cur_bank <= start_bank;
    end else if (busy && ready) begin
      if (ptr == LW'(NLAG - 1)) busy <= 1'b0;
      else                      ptr  <= ptr + 1'b1;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !start) |=> (valid && $stable(ptr) && $stable(cur_bank)));

  assert_end_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && last && !start) |=> !valid);

endmodule

// File: rtl/seg_integrator.sv
module seg_integrator
  import segint_pkg::*;
#(
  parameter int NSLICE = 32,
  parameter int PW     = 4,
  parameter int AW     = 24,
  parameter int NLAG   = 64,
  parameter int CW     = 8,
  localparam int LW    = (NLAG > 1) ? $clog2(NLAG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        int_segs,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LW-1:0]        in_lag,
  input  logic                 in_last,
  input  logic [NSLICE*PW-1:0] in_part,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [AW-1:0]        out_data,
  output logic                 out_last,
  output logic                 dump_ovf,
  output logic                 dump_late
);

  localparam int SW    = PW + $clog2(NSLICE) + 1;
  localparam int DEPTH = 2 * NLAG;
  localparam int IW    = $clog2(DEPTH);

  function automatic logic [IW-1:0] slot(input logic bank, input logic [LW-1:0] lag);
    return IW'(bank ? NLAG : 0) + IW'(lag);
  endfunction

  // Stage A: accept, slice total, memory read
  logic                 act_bank, first_pass;
  logic [CW-1:0]        seg_cnt;
  logic                 seg_end, cnt_hit, swap_now;
  logic signed [SW-1:0] sum_c;

  assign in_ready = 1'b1;
  assign seg_end  = in_valid && in_last;
  assign cnt_hit  = (32'(seg_cnt) + 32'd1) >= eff_len(32'(int_segs));
  assign swap_now = seg_end && cnt_hit;

  segint_slice_sum #(.NSLICE(NSLICE), .PW(PW), .SW(SW)) u_sum (
    .part (in_part),
    .sum  (sum_c)
  );

  // Stage B: modify and write back
  logic                 b_valid, b_bank, b_first, b_end;
  logic [LW-1:0]        b_addr;
  logic signed [SW-1:0] b_sum;
  logic [AW-1:0]        rd_q;
  logic                 f_valid, f_bank;
  logic [LW-1:0]        f_addr;
  logic [AW-1:0]        f_val;
  logic                 fwd_hit, sat_c, ovf_run, rd_start;
  logic signed [AW-1:0] old_v, new_v;
  logic [AW-1:0]        mem [DEPTH];
  logic [IW-1:0]        rd_addr;
  logic                 rd_bank;

  assign fwd_hit  = f_valid && (f_addr == b_addr) && (f_bank == b_bank);
  assign old_v    = b_first ? '0 : (fwd_hit ? f_val : rd_q);
  assign rd_start = b_valid && b_end;

  segint_sat_add #(.AW(AW), .SW(SW)) u_add (
    .base   (old_v),
    .addend (b_sum),
    .res    (new_v),
    .sat    (sat_c)
  );

  always_ff @(posedge clk) begin
    if (in_valid) rd_q <= mem[slot(act_bank, in_lag)];
    if (b_valid)  mem[slot(b_bank, b_addr)] <= new_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bank   <= 1'b0;
      first_pass <= 1'b1;
      seg_cnt    <= '0;
      b_valid    <= 1'b0;
      b_bank     <= 1'b0;
      b_first    <= 1'b0;
      b_end      <= 1'b0;
      b_addr     <= '0;
      b_sum      <= '0;
      f_valid    <= 1'b0;
      f_bank     <= 1'b0;
      f_addr     <= '0;
      f_val      <= '0;
      ovf_run    <= 1'b0;
      dump_ovf   <= 1'b0;
      dump_late  <= 1'b0;
    end else begin
      if (seg_end) begin
        if (cnt_hit) begin
          seg_cnt    <= '0;
          act_bank   <= ~act_bank;
          first_pass <= 1'b1;
        end else begin
          seg_cnt    <= seg_cnt + 1'b1;
          first_pass <= 1'b0;
        end
      end
      b_valid <= in_valid;
      if (in_valid) begin
        b_bank  <= act_bank;
        b_first <= first_pass;
        b_end   <= swap_now;
        b_addr  <= in_lag;
        b_sum   <= sum_c;
      end
      f_valid <= b_valid;
      f_bank  <= b_bank;
      f_addr  <= b_addr;
      f_val   <= new_v;
      if (b_valid) begin
        if (b_end) begin
          dump_ovf  <= ovf_run | sat_c;
          dump_late <= out_valid;
          ovf_run   <= 1'b0;
        end else begin
          ovf_run <= ovf_run | sat_c;
        end
      end
    end
  end

  segint_readout #(.NLAG(NLAG), .LW(LW), .IW(IW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start),
    .start_bank (b_bank),
    .ready      (out_ready),
    .valid      (out_valid),
    .last       (out_last),
    .addr       (rd_addr),
    .cur_bank   (rd_bank)
  );

  assign out_data = mem[rd_addr];

  // Same-lag update on the previous cycle must be served by the bypass.
  assert_fwd_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && $past(b_valid) && ($past(b_addr) == b_addr) && ($past(b_bank) == b_bank))
      |-> fwd_hit);

  // Readout and accumulation never share a bank right after a dump.
  assert_bank_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (out_valid && (rd_bank != act_bank)));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> ($stable(dump_ovf) && $stable(dump_late)));

  assert_in_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(in_valid));

endmodule

// File: tb/test_seg_integrator.sv
module test_seg_integrator;
  localparam int NSL  = 32;
  localparam int PW   = 4;
  localparam int AW   = 10;
  localparam int NLAG = 8;
  localparam int CW   = 4;
  localparam int LW   = 3;
  localparam int AMAX = (1 << (AW-1)) - 1;
  localparam int AMIN = -(1 << (AW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0]     int_segs;
  logic              in_valid, in_ready, in_last;
  logic [LW-1:0]     in_lag;
  logic [NSL*PW-1:0] in_part;
  logic              out_valid, out_last, dump_ovf, dump_late;
  logic              out_ready = 1'b0;
  logic [AW-1:0]     out_data;

  seg_integrator #(.NSLICE(NSL), .PW(PW), .AW(AW), .NLAG(NLAG), .CW(CW)) i_seg_integrator (
    .clk(clk), .rst_n(rst_n), .int_segs(int_segs),
    .in_valid(in_valid), .in_ready(in_ready), .in_lag(in_lag), .in_last(in_last),
    .in_part(in_part), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .dump_ovf(dump_ovf), .dump_late(dump_late)
  );

  int errors = 0, checks = 0;
  int model [NLAG];
  int exp_dump [NLAG];
  int exp_idx = NLAG;
  string exp_tag = "R2";
  bit armed = 0, hold_v = 0, hold_l = 0, tail_pend = 0, model_ovf = 0;
  int hold_d = 0;
  int ready_mode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sval(input logic [AW-1:0] v);
    return int'($signed(v));
  endfunction

  // Readout collector: decides out_ready at each falling edge.
  always @(negedge clk) begin
    if (!armed) begin
      out_ready = 1'b0; hold_v = 0; tail_pend = 0;
    end else begin
      if (tail_pend) begin
        check(!out_valid, "R8 valid low after last", int'(out_valid), 0);
        tail_pend = 0;
      end
      if (hold_v) begin
        check(out_valid && sval(out_data) == hold_d && out_last == hold_l,
              "R8 hold under stall", sval(out_data), hold_d);
        hold_v = 0;
      end
      if (exp_idx >= NLAG || ready_mode == 1) out_ready = 1'b0;
      else if (ready_mode == 2)               out_ready = 1'b1;
      else                                    out_ready = ($urandom % 4) != 0;
      if (out_valid && exp_idx < NLAG) begin
        if (out_ready) begin
          check(sval(out_data) == exp_dump[exp_idx], {exp_tag, " readout sum"},
                sval(out_data), exp_dump[exp_idx]);
          check(out_last == (exp_idx == NLAG-1), "R8 last marker",
                int'(out_last), int'(exp_idx == NLAG-1));
          exp_idx++;
          if (exp_idx == NLAG) tail_pend = 1;
        end else begin
          hold_v = 1; hold_d = sval(out_data); hold_l = out_last;
        end
      end
    end
  end

  // kind: 0 random with gaps, 1 all +max, 2 all -min, 3 alternating order, no gaps
  task automatic run_integ(input int prog, input int kind, input bit arm, input bit exp_late,
                           input string tag);
    int nseg;
    int perm [NLAG];
    nseg = (prog == 0) ? 1 : prog;
    int_segs = CW'(prog);
    model_ovf = 0;
    for (int s = 0; s < nseg; s++) begin
      for (int i = 0; i < NLAG; i++) perm[i] = (kind == 3 && s % 2 == 0) ? NLAG-1-i : i;
      if (kind == 0) begin
        for (int i = NLAG-1; i > 0; i--) begin
          int j, t;
          j = int'($urandom % (i+1)); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
      end
      for (int i = 0; i < NLAG; i++) begin
        int sum, v;
        sum = 0;
        if (kind == 0 && ($urandom % 4) == 0) begin in_valid = 0; @(negedge clk); end
        for (int g = 0; g < NSL; g++) begin
          logic [PW-1:0] p;
          p = (kind == 1) ? PW'(7) : (kind == 2) ? PW'(8) : PW'($urandom);
          in_part[g*PW +: PW] = p;
          sum += int'($signed(p));
        end
        in_valid = 1; in_lag = LW'(perm[i]); in_last = (i == NLAG-1);
        check(in_ready == 1'b1, "R1 input never stalled", int'(in_ready), 1);
        if (s == 0) model[perm[i]] = sum;
        else begin
          v = model[perm[i]] + sum;
          if (v > AMAX) begin v = AMAX; model_ovf = 1; end
          else if (v < AMIN) begin v = AMIN; model_ovf = 1; end
          model[perm[i]] = v;
        end
        @(negedge clk);
      end
    end
    in_valid = 0; in_last = 0;
    @(negedge clk);
    check(dump_ovf == model_ovf, "R7 overflow flag", int'(dump_ovf), int'(model_ovf));
    check(dump_late == exp_late, "R9 late flag", int'(dump_late), int'(exp_late));
    for (int i = 0; i < NLAG; i++) exp_dump[i] = model[i];
    exp_tag = tag; hold_v = 0; tail_pend = 0;
    exp_idx = arm ? 0 : NLAG;
    armed = arm;
  endtask

  task automatic drain();
    ready_mode = 0;
    for (int t = 0; t < 600 && (exp_idx < NLAG || tail_pend); t++) @(negedge clk);
    check(exp_idx == NLAG, "R8 readout completes", exp_idx, NLAG);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    in_valid = 0; in_lag = '0; in_last = 0; in_part = '0; int_segs = CW'(1);
    repeat (3) @(negedge clk);
    check(!out_valid && !dump_ovf && !dump_late, "R10 state in reset",
          int'({out_valid, dump_ovf, dump_late}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !dump_ovf && !dump_late && in_ready, "R10 state after reset",
          int'({out_valid, dump_ovf, dump_late}), 0);

    run_integ(3, 0, 1, 0, "R2");         drain();
    run_integ(0, 0, 1, 0, "R4 zero");    drain();   // zero treated as one segment
    run_integ(4, 1, 1, 0, "R6 pos");     drain();
    run_integ(1, 0, 1, 0, "R3 clear");   drain();   // flag must drop again (R7)
    run_integ(4, 2, 1, 0, "R6 neg");     drain();
    run_integ(5, 3, 1, 0, "R5 bypass");  drain();
    ready_mode = 2;                                 // readout overlaps input (R1)
    run_integ(2, 0, 1, 0, "R3 a");
    run_integ(3, 0, 1, 0, "R3 b");       drain();
    ready_mode = 1;                                 // overrun (R9)
    run_integ(2, 0, 0, 0, "R9 lost");
    run_integ(1, 0, 1, 1, "R9 restart"); drain();
    for (int k = 0; k < 6; k++) begin
      run_integ(1 + int'($urandom % 4), (($urandom % 2) != 0) ? 3 : 0, 1, 0, "R2 rnd");
      drain();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule